// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block carries out one string primitive per start pulse: move, load, store, compare or scan, each in byte or word size. It can run once or under a repeat prefix that counts down a count register. The block holds its own source pointer, destination pointer, count register and accumulator. It takes a direction input and two segment bases, and it runs every element through a single memory request port that waits for an acknowledge.

Compare and scan subtract the destination element from the source element or from the accumulator and update six arithmetic flags. The two conditional repeat codes use the zero flag to stop the loop early. A surrounding execution unit loads the starting values with `start` and waits for `done`. After `done` it reads the final pointers, count, accumulator and flags from the output ports, which hold their values.

Top module: `strop_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are 0, and `si`, `di`, `cx`, `acc` and `flags` are all zero.
- R2: The request address is `(segment << 4) + offset`, truncated to 20 bits. Source accesses use `ds_init` with the source pointer and drive `mem_es`=0. Destination accesses use `es_init` with the destination pointer and drive `mem_es`=1.
- R3: After each element, every pointer the primitive uses moves by 1 (byte, `wide`=0) or 2 (word, `wide`=1). It moves up when `dir`=0 and down when `dir`=1.
- R4: Move (`op`=0) reads the source element, writes it to the destination, and steps both pointers.
- R5: Load (`op`=1) reads the source into the low byte of `acc`, leaving the high byte unchanged, or into all of `acc` for a word, and steps only the source pointer. Store (`op`=2) writes the low byte of `acc` or the whole `acc` to the destination and steps only the destination pointer.
- R6: Compare (`op`=3) reads source then destination and computes source minus destination without writing memory. `flags` = {OF,SF,ZF,AF,PF,CF} (bit 5 down to 0). CF is the borrow, ZF means a zero result, SF is the result's top bit, OF is signed overflow, AF is the borrow out of bit 3, and PF is 1 when the result's low 8 bits hold an even number of ones.
- R7: Scan (`op`=4) reads the destination, computes `acc` (or its low byte) minus that element, sets `flags` as in R6, and steps only the destination pointer.
- R8: With a repeat code (`rep`≠0) and a starting count of zero, no memory access takes place and the pointers and count stay unchanged before `done`.
- R9: Unconditional repeat (`rep`=1) on move, load or store performs exactly `cx_init` elements and ends with a count of zero.
- R10: On compare or scan, `rep`=2 (while equal) stops after an element that leaves ZF=0, and `rep`=3 (while not equal) stops after an element that leaves ZF=1. Both also stop when the count reaches zero. The count drops by one per element.
- R11: On move, load and store, codes 2 and 3 count like code 1 and ignore ZF. On compare and scan, code 1 behaves as code 2.
- R12: A request holds its address, write enable and data until `mem_ack`, and each element access completes exactly one acknowledged transfer. Words are one 16-bit little-endian transfer.
- R13: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a single-cycle pulse. A `start` while busy is ignored.
- R14: With no repeat code (`rep`=0), exactly one element is performed and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 3 | 0 move, 1 load, 2 store, 3 compare, 4 scan |
| rep | input | 2 | 0 single, 1 repeat, 2 repeat while equal, 3 repeat while not equal |
| wide | input | 1 | 1 selects word elements |
| dir | input | 1 | 1 steps pointers downward |
| si_init | input | 16 | Starting source pointer |
| di_init | input | 16 | Starting destination pointer |
| cx_init | input | 16 | Starting count |
| acc_init | input | 16 | Starting accumulator |
| ds_init | input | 16 | Source segment base |
| es_init | input | 16 | Destination segment base |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_es | output | 1 | Request uses the destination segment |
| mem_wide | output | 1 | Request is a 16-bit transfer |
| mem_addr | output | 20 | Physical address |
| mem_wdata | output | 16 | Write data (byte in bits 7:0) |
| mem_rdata | input | 16 | Read data, valid with ack |
| mem_ack | input | 1 | Transfer complete |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| si | output | 16 | Source pointer |
| di | output | 16 | Destination pointer |
| cx | output | 16 | Count |
| acc | output | 16 | Accumulator |
| flags | output | 6 | {OF,SF,ZF,AF,PF,CF} |

## Verification
`busy` rises at the clock edge that samples `start`. A repeated operation with a zero count raises `done` two edges after `start`. Each element costs one decision cycle and one step cycle. Each memory transfer adds the acknowledge latency plus two cycles, so the delay to `done` depends on the memory wait states the bench chooses. For that reason the scoreboard does not count cycles. It pops the expected pointers, count, accumulator, flags, transfer count and first address on the falling edge where `done` is high, and it checks on the next falling edge that `done` and `busy` have returned low.

// File: rtl/strop_pkg.sv
// Shared encodings for the string sequencer.
// Assumes op/rep codes are driven exactly as listed in the brief.
package strop_pkg;
    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_CMP   = 3'd3,
        OP_SCAN  = 3'd4
    } str_op_e;

    typedef enum logic [1:0] {
        RP_NONE = 2'd0,
        RP_ALL  = 2'd1,
        RP_EQ   = 2'd2,
        RP_NE   = 2'd3
    } rep_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flags_t;
endpackage

// File: rtl/strop_addr.sv
// Physical address former: segment shifted left plus offset, truncated.
// Assumes PAW <= AW + SEG_SHIFT, so truncation only drops carry bits.
module strop_addr #(
    parameter int AW        = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PAW       = 20
) (
    input  logic [AW-1:0]  seg,
    input  logic [AW-1:0]  off,
    output logic [PAW-1:0] phys
);
    localparam int SUMW = AW + SEG_SHIFT;

    logic [SUMW-1:0] sum;

    // Form the widened sum and keep the low PAW bits.
    always_comb begin
        sum  = {seg, {SEG_SHIFT{1'b0}}} + SUMW'(off);
        phys = sum[PAW-1:0];
    end
endmodule

// File: rtl/strop_alu.sv
// Subtract-and-flag unit for compare and scan, byte or word width.
// Assumes DW is even; the byte form uses the low half of each operand.
module strop_alu import strop_pkg::*; #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          wide,
    output flags_t        fl
);
    localparam int HW = DW / 2;

    logic [DW:0] diff_w;
    logic [HW:0] diff_b;
    logic [DW-1:0] res;
    logic a_top, b_top, r_top;

    // Compute both widths and pick flags for the selected one.
    always_comb begin
        diff_w = {1'b0, a} - {1'b0, b};
        diff_b = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]};
        res    = wide ? diff_w[DW-1:0] : DW'(diff_b[HW-1:0]);
        a_top  = wide ? a[DW-1] : a[HW-1];
        b_top  = wide ? b[DW-1] : b[HW-1];
        r_top  = wide ? res[DW-1] : res[HW-1];
        fl.cf  = wide ? diff_w[DW] : diff_b[HW];
        fl.zf  = (res == '0);
        fl.sf  = r_top;
        fl.of  = (a_top != b_top) && (r_top != a_top);
        fl.af  = (a[3:0] < b[3:0]);
        fl.pf  = ~^res[7:0];
    end
endmodule

// File: rtl/strop_ctrl.sv
// Element sequencer: holds pointers, count, accumulator and flags, and
// steps one element per pass through CHECK -> SRC/DST -> STEP.
// Assumes the memory side keeps mem_ack low until a request is seen.
module strop_ctrl import strop_pkg::*; #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_i,
    input  logic [1:0]    rep_i,
    input  logic          wide_i,
    input  logic          dir_i,
    input  logic [AW-1:0] si_init,
    input  logic [AW-1:0] di_init,
    input  logic [AW-1:0] cx_init,
    input  logic [DW-1:0] acc_init,
    input  logic [AW-1:0] ds_init,
    input  logic [AW-1:0] es_init,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  flags_t        alu_fl,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_es,
    output logic          mem_wide,
    output logic [AW-1:0] mem_seg,
    output logic [AW-1:0] mem_off,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] alu_a,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] si,
    output logic [AW-1:0] di,
    output logic [AW-1:0] cx,
    output logic [DW-1:0] acc,
    output flags_t        flags
);
    localparam int HW = DW / 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_SRC, ST_DST, ST_STEP, ST_DONE
    } st_e;

    st_e           state;
    str_op_e       op_q;
    rep_e          rep_q;
    logic          wide_q, dir_q;
    logic [AW-1:0] si_q, di_q, cx_q, ds_q, es_q;
    logic [DW-1:0] acc_q, tmp_q;
    flags_t        fl_q;

    logic          use_src, use_dst, counted, is_test, stop_eq, stop_ne, finish;
    logic [AW-1:0] step, cx_dec;

    // Decode per-operation roles and the loop exit condition.
    always_comb begin
        use_src = (op_q == OP_MOVE) || (op_q == OP_LOAD) || (op_q == OP_CMP);
        use_dst = (op_q != OP_LOAD);
        is_test = (op_q == OP_CMP) || (op_q == OP_SCAN);
        counted = (rep_q != RP_NONE);
        stop_eq = is_test && (rep_q == RP_ALL || rep_q == RP_EQ) && !fl_q.zf;
        stop_ne = is_test && (rep_q == RP_NE) && fl_q.zf;
        step    = wide_q ? AW'(2) : AW'(1);
        cx_dec  = cx_q - AW'(1);
        finish  = !counted || (cx_dec == '0) || stop_eq || stop_ne;
    end

    // Drive the memory request from the current access phase.
    always_comb begin
        mem_req   = (state == ST_SRC) || (state == ST_DST);
        mem_es    = (state == ST_DST);
        mem_we    = (state == ST_DST) && (op_q == OP_MOVE || op_q == OP_STORE);
        mem_wide  = wide_q;
        mem_seg   = mem_es ? es_q : ds_q;
        mem_off   = mem_es ? di_q : si_q;
        mem_wdata = (op_q == OP_MOVE) ? tmp_q : acc_q;
        if (!wide_q)
            mem_wdata = DW'(mem_wdata[HW-1:0]);
        alu_a     = (op_q == OP_CMP) ? tmp_q : acc_q;
    end

    // Sequence states and update architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_MOVE;
            rep_q  <= RP_NONE;
            wide_q <= 1'b0;
            dir_q  <= 1'b0;
            si_q   <= '0;
            di_q   <= '0;
            cx_q   <= '0;
            ds_q   <= '0;
            es_q   <= '0;
            acc_q  <= '0;
            tmp_q  <= '0;
            fl_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    op_q   <= str_op_e'(op_i);
                    rep_q  <= rep_e'(rep_i);
                    wide_q <= wide_i;
                    dir_q  <= dir_i;
                    si_q   <= si_init;
                    di_q   <= di_init;
                    cx_q   <= cx_init;
                    acc_q  <= acc_init;
                    ds_q   <= ds_init;
                    es_q   <= es_init;
                    state  <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (counted && cx_q == '0) state <= ST_DONE;
                    else if (use_src)          state <= ST_SRC;
                    else                       state <= ST_DST;
                end
                ST_SRC: if (mem_ack) begin
                    if (op_q == OP_LOAD) begin
                        acc_q <= wide_q ? mem_rdata : {acc_q[DW-1:HW], mem_rdata[HW-1:0]};
                        state <= ST_STEP;
                    end else begin
                        tmp_q <= mem_rdata;
                        state <= ST_DST;
                    end
                end
                ST_DST: if (mem_ack) begin
                    if (is_test) fl_q <= alu_fl;
                    state <= ST_STEP;
                end
                ST_STEP: begin
                    if (use_src) si_q <= dir_q ? si_q - step : si_q + step;
                    if (use_dst) di_q <= dir_q ? di_q - step : di_q + step;
                    if (counted) cx_q <= cx_dec;
                    state <= finish ? ST_DONE : ST_CHECK;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy  = (state != ST_IDLE);
    assign done  = (state == ST_DONE);
    assign si    = si_q;
    assign di    = di_q;
    assign cx    = cx_q;
    assign acc   = acc_q;
    assign flags = fl_q;

    // R3
    si_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && si_q != $past(si_q)) |->
        (si_q - $past(si_q) == step || $past(si_q) - si_q == step));

    // R10
    cx_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cx_q == $past(cx_q) || cx_q == $past(cx_q) - AW'(1)));

    // R6
    test_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && is_test) |-> !mem_we);
endmodule

// File: rtl/strop_seq.sv
// Top of the string sequencer: control, address former and flag unit.
// Assumes a single outstanding memory transfer, acknowledged by mem_ack.
module strop_seq import strop_pkg::*; #(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PAW       = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     op,
    input  logic [1:0]     rep,
    input  logic           wide,
    input  logic           dir,
    input  logic [AW-1:0]  si_init,
    input  logic [AW-1:0]  di_init,
    input  logic [AW-1:0]  cx_init,
    input  logic [DW-1:0]  acc_init,
    input  logic [AW-1:0]  ds_init,
    input  logic [AW-1:0]  es_init,
    output logic           mem_req,
    output logic           mem_we,
    output logic           mem_es,
    output logic           mem_wide,
    output logic [PAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    output logic           busy,
    output logic           done,
    output logic [AW-1:0]  si,
    output logic [AW-1:0]  di,
    output logic [AW-1:0]  cx,
    output logic [DW-1:0]  acc,
    output logic [5:0]     flags
);
    logic [AW-1:0] seg_w, off_w;
    logic [DW-1:0] alu_a_w;
    flags_t        alu_fl_w, fl_w;

    strop_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_i(op), .rep_i(rep),
        .wide_i(wide), .dir_i(dir), .si_init(si_init), .di_init(di_init),
        .cx_init(cx_init), .acc_init(acc_init), .ds_init(ds_init),
        .es_init(es_init), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .alu_fl(alu_fl_w), .mem_req(mem_req), .mem_we(mem_we),
        .mem_es(mem_es), .mem_wide(mem_wide), .mem_seg(seg_w),
        .mem_off(off_w), .mem_wdata(mem_wdata), .alu_a(alu_a_w),
        .busy(busy), .done(done), .si(si), .di(di), .cx(cx), .acc(acc),
        .flags(fl_w)
    );

    strop_addr #(.AW(AW), .SEG_SHIFT(SEG_SHIFT), .PAW(PAW)) u_addr (
        .seg(seg_w), .off(off_w), .phys(mem_addr)
    );

    strop_alu #(.DW(DW)) u_alu (
        .a(alu_a_w), .b(mem_rdata), .wide(mem_wide), .fl(alu_fl_w)
    );

    assign flags = fl_w;

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);
endmodule

// File: tb/tb_strop_seq.sv
`timescale 1ns/1ps
module tb_strop_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  rep = '0;
    logic        wide = 1'b0, dir = 1'b0;
    logic [15:0] si_init = '0, di_init = '0, cx_init = '0, acc_init = '0;
    logic [15:0] ds_init = '0, es_init = '0;
    logic        mem_req, mem_we, mem_es, mem_wide, busy, done;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, si, di, cx, acc;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [5:0]  flags;

    always #2 clk = ~clk;

    strop_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rep(rep),
        .wide(wide), .dir(dir), .si_init(si_init), .di_init(di_init),
        .cx_init(cx_init), .acc_init(acc_init), .ds_init(ds_init),
        .es_init(es_init), .mem_req(mem_req), .mem_we(mem_we),
        .mem_es(mem_es), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .si(si), .di(di), .cx(cx), .acc(acc),
        .flags(flags)
    );

    int n_checks = 0, n_fail = 0, cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model and its shadow copy used by the reference model.
    logic [7:0] mem  [4096];
    logic [7:0] smem [4096];
    int         lat = 0, wcnt = 0, n_acc = 0;
    logic [19:0] first_addr = '0;
    logic [11:0] idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt = 0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt >= lat) begin
                wcnt = 0;
                idx  = mem_addr[11:0];
                if (n_acc == 0) first_addr = mem_addr;
                n_acc++;
                if (mem_we) begin
                    mem[idx] = mem_wdata[7:0];
                    if (mem_wide) mem[idx + 12'd1] = mem_wdata[15:8];
                end else begin
                    mem_rdata <= {mem[idx + 12'd1], mem[idx]};
                end
                mem_ack <= 1'b1;
            end else begin
                wcnt++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Scoreboard queues.
    typedef struct packed {
        logic [15:0] si, di, cx, acc;
        logic [5:0]  fl;
        logic [7:0]  n;
        logic [19:0] a0;
    } exp_t;
    exp_t  q[$];
    string tq[$];
    logic [5:0] mflags = '0;

    function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
        return 20'({seg, 4'h0} + {4'h0, off});
    endfunction

    function automatic logic [15:0] srd(input logic [19:0] a, input bit w);
        logic [11:0] i = a[11:0];
        return w ? {smem[i + 12'd1], smem[i]} : {8'h00, smem[i]};
    endfunction

    task automatic swr(input logic [19:0] a, input logic [15:0] v, input bit w);
        logic [11:0] i = a[11:0];
        smem[i] = v[7:0];
        if (w) smem[i + 12'd1] = v[15:8];
    endtask

    function automatic logic [5:0] ref_flags(input logic [15:0] a, input logic [15:0] b, input bit w);
        int bits = w ? 16 : 8;
        int ua = w ? int'(a) : int'(a[7:0]);
        int ub = w ? int'(b) : int'(b[7:0]);
        int r = (ua - ub) & ((1 << bits) - 1);
        int ones = 0;
        bit cf, zf, sf, of, af, pf, sa, sb;
        for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
        cf = ua < ub;
        zf = (r == 0);
        sf = ((r >> (bits - 1)) & 1) != 0;
        sa = ((ua >> (bits - 1)) & 1) != 0;
        sb = ((ub >> (bits - 1)) & 1) != 0;
        of = (sa != sb) && (sf != sa);
        af = (ua & 15) < (ub & 15);
        pf = (ones % 2) == 0;
        return {of, sf, zf, af, pf, cf};
    endfunction

    task automatic poke(input int a, input logic [7:0] v);
        mem[a[11:0]]  = v;
        smem[a[11:0]] = v;
    endtask

    // Driver: model the expected outcome, push it, then run the DUT.
    task automatic run_op(input string tag, input int o, input int r, input bit w, input bit d,
                          input logic [15:0] s0, input logic [15:0] d0, input logic [15:0] c0,
                          input logic [15:0] a0i, input logic [15:0] ds, input logic [15:0] es,
                          input int l, input bit extra);
        logic [15:0] s = s0, dd = d0, c = c0, a = a0i, v, b;
        logic [19:0] sa, da, fa = '0;
        int n = 0;
        bit counted = (r != 0);
        logic [15:0] st = w ? 16'd2 : 16'd1;
        exp_t e;
        int mism = 0;
        forever begin
            if (counted && c == 16'd0) break;
            sa = phys(ds, s);
            da = phys(es, dd);
            if (n == 0) fa = (o == 2 || o == 4) ? da : sa;
            case (o)
                0: begin v = srd(sa, w); swr(da, v, w); n += 2; end
                1: begin v = srd(sa, w); a = w ? v : {a[15:8], v[7:0]}; n += 1; end
                2: begin swr(da, a, w); n += 1; end
                3: begin v = srd(sa, w); b = srd(da, w); mflags = ref_flags(v, b, w); n += 2; end
                default: begin b = srd(da, w); mflags = ref_flags(a, b, w); n += 1; end
            endcase
            if (o == 0 || o == 1 || o == 3) s = d ? s - st : s + st;
            if (o != 1) dd = d ? dd - st : dd + st;
            if (!counted) break;
            c = c - 16'd1;
            if (c == 16'd0) break;
            if (o >= 3) begin
                if ((r == 1 || r == 2) && !mflags[3]) break;
                if (r == 3 && mflags[3]) break;
            end
        end
        e.si = s; e.di = dd; e.cx = c; e.acc = a; e.fl = mflags;
        e.n = 8'(n); e.a0 = fa;
        q.push_back(e);
        tq.push_back(tag);

        @(negedge clk);
        lat = l;
        op = 3'(o); rep = 2'(r); wide = w; dir = d;
        si_init = s0; di_init = d0; cx_init = c0; acc_init = a0i;
        ds_init = ds; es_init = es;
        n_acc = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R13", {tag, " busy after start"}, busy, 1);
        if (extra && !done) begin
            @(negedge clk);
            op = 3'd2; rep = 2'd0; si_init = 16'h0BAD; di_init = 16'h0BAD;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!done && !busy, "R13", {tag, " done/busy low after pulse"}, {done, busy}, 0);
        for (int i = 0; i < 4096; i++) if (mem[i] !== smem[i]) mism++;
        chk(mism == 0, tag, "memory image mismatches", mism, 0);
    endtask

    // Monitor: compare results in the cycle done is high.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R13", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                string t;
                e = q.pop_front();
                t = tq.pop_front();
                chk(si == e.si, t, "si", si, e.si);
                chk(di == e.di, t, "di", di, e.di);
                chk(cx == e.cx, t, "cx", cx, e.cx);
                chk(acc == e.acc, t, "acc", acc, e.acc);
                chk(flags == e.fl, t, "flags", flags, e.fl);
                chk(n_acc == int'(e.n), t, "transfer count (R12)", n_acc, e.n);
                if (e.n != 0) chk(first_addr == e.a0, t, "first address (R2)", first_addr, e.a0);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(1'b0, "WDOG", "watchdog expired", cycles, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            smem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mem_req, "R1", "idle controls", {busy, done, mem_req}, 0);
        chk(si == 0 && di == 0 && cx == 0 && acc == 0 && flags == 0, "R1", "registers zero",
            {si, di, cx}, 0);

        // R4 R14 single byte move, count untouched
        run_op("R14", 0, 0, 0, 0, 16'h0005, 16'h0040, 16'd7, 16'h0, 16'h0010, 16'h0020, 0, 0);
        // R9 R3 word move upward, repeated
        run_op("R9", 0, 1, 1, 0, 16'h0000, 16'h0010, 16'd3, 16'h0, 16'h0030, 16'h0040, 1, 0);
        // R3 R4 byte move downward, repeated
        run_op("R3", 0, 1, 0, 1, 16'h000F, 16'h002F, 16'd4, 16'h0, 16'h0050, 16'h0050, 2, 0);
        // R8 zero count
        run_op("R8", 0, 1, 0, 0, 16'h0011, 16'h0022, 16'd0, 16'h0, 16'h0050, 16'h0050, 0, 0);
        // R5 byte load keeps high byte
        run_op("R5", 1, 0, 0, 0, 16'h0003, 16'h0000, 16'd1, 16'hAB12, 16'h0060, 16'h0000, 1, 0);
        // R5 word load repeated
        run_op("R5", 1, 1, 1, 0, 16'h0000, 16'h0000, 16'd3, 16'h0, 16'h0060, 16'h0000, 0, 0);
        // R5 word store downward
        run_op("R5", 2, 1, 1, 1, 16'h0000, 16'h0020, 16'd2, 16'hBEEF, 16'h0000, 16'h0070, 3, 0);

        // R10 compare while equal stops on third element
        poke(12'h800, 8'h11); poke(12'h801, 8'h22); poke(12'h802, 8'h33);
        poke(12'h803, 8'h44); poke(12'h804, 8'h55);
        poke(12'h900, 8'h11); poke(12'h901, 8'h22); poke(12'h902, 8'h99);
        poke(12'h903, 8'h44); poke(12'h904, 8'h55);
        run_op("R10", 3, 2, 0, 0, 16'h0000, 16'h0000, 16'd5, 16'h0, 16'h0080, 16'h0090, 1, 0);
        // R7 R10 scan while not equal finds match on fourth
        poke(12'hA00, 8'h01); poke(12'hA01, 8'h02); poke(12'hA02, 8'h03);
        poke(12'hA03, 8'h44); poke(12'hA04, 8'h05); poke(12'hA05, 8'h06);
        run_op("R7", 4, 3, 0, 0, 16'h0000, 16'h0000, 16'd6, 16'h0044, 16'h0000, 16'h00A0, 0, 0);
        // R10 word scan without match runs count out
        run_op("R10", 4, 3, 1, 0, 16'h0000, 16'h0000, 16'd3, 16'hFFFF, 16'h0000, 16'h00B0, 0, 0);
        // R11 code 1 on compare acts as while-equal
        run_op("R11", 3, 1, 0, 0, 16'h0000, 16'h0000, 16'd5, 16'h0, 16'h0080, 16'h0090, 0, 0);
        // R6 single compare equal sets ZF
        run_op("R6", 3, 0, 0, 0, 16'h0000, 16'h0000, 16'd9, 16'h0, 16'h0080, 16'h0090, 0, 0);
        // R11 move under while-not-equal ignores ZF=1
        run_op("R11", 0, 3, 0, 0, 16'h0000, 16'h0000, 16'd3, 16'h0, 16'h00C0, 16'h00D0, 0, 0);
        // R6 byte compare with signed overflow
        poke(12'hE00, 8'h80); poke(12'hE10, 8'h01);
        run_op("R6", 3, 0, 0, 0, 16'h0000, 16'h0010, 16'd0, 16'h0, 16'h00E0, 16'h00E0, 2, 0);
        // R6 word compare with signed overflow
        poke(12'hE20, 8'h00); poke(12'hE21, 8'h80); poke(12'hE30, 8'h01); poke(12'hE31, 8'h00);
        run_op("R6", 3, 0, 1, 0, 16'h0020, 16'h0030, 16'd0, 16'h0, 16'h00E0, 16'h00E0, 0, 0);
        // R2 20-bit wrap of the physical address
        run_op("R2", 1, 0, 0, 0, 16'h0020, 16'h0000, 16'd0, 16'h0000, 16'hFFFF, 16'h0000, 0, 0);
        // R13 start during busy is ignored
        run_op("R13", 0, 1, 1, 0, 16'h0000, 16'h0000, 16'd2, 16'h0, 16'h00F0, 16'h00F8, 2, 1);

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R13", "pending expectations", q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule